// File: doc/BRIEF.md
# Registered Bidirectional Barrel Shifter

This block moves a 16-bit word left or right by any distance from 0 to 15 bit positions in a single pass. A direction input picks left or right. A signedness input picks how a right shift fills the vacated upper bits: with copies of the word's top bit (two's-complement arithmetic shift) or with zeros (logical shift). Left shifts always fill the vacated low bits with zeros.

Every input is captured in a register on the rising clock edge. The shift network is purely combinational from those registers, so each result appears one clock after its operands are presented. The network is a cascade of one stage per bit of the shift amount. Stage k moves the word by 2^k positions when its amount bit is set, and every stage serves both directions. An active-low asynchronous reset clears the input registers, so the output reads zero during and after reset until new operands are captured.

Top module: `barrel_shift16`

## Requirements
- R1: The output reflects the operands that were present at the most recent rising clock edge. A change on any input does not alter the output before the next rising edge.
- R2: While rst_ni is low, the output is 16'h0000. It stays 16'h0000 until operands are captured at a rising edge with rst_ni high.
- R3: With right_i = 0 the word shifts left by amt_i positions, and the vacated low bits are 0 whatever the value of signed_i.
- R4: With right_i = 1 and signed_i = 0 the word shifts right by amt_i positions, and the vacated high bits are 0.
- R5: With right_i = 1 and signed_i = 1 the word shifts right by amt_i positions, and each vacated high bit equals bit 15 of the captured word.
- R6: An amt_i of 0 passes the captured word through unchanged for every combination of right_i and signed_i.
- R7: A signed right shift by 15 gives 16'hFFFF when bit 15 of the captured word is 1, and 16'h0000 when it is 0.
- R8: Every distance from 0 to 15 is reached correctly in each of the three modes (left, logical right, arithmetic right).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; operands are captured on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the operand registers |
| data_i | input | 16 | Word to be shifted |
| amt_i | input | 4 | Unsigned shift distance, 0 to 15 |
| right_i | input | 1 | 1 = shift right, 0 = shift left |
| signed_i | input | 1 | 1 = right shifts replicate bit 15, 0 = right shifts fill with zeros |
| data_o | output | 16 | Shifted word, combinational from the operand registers |

## Verification
Each shifted result is due exactly one rising edge after its operands are driven. The reset value is due immediately when rst_ni falls, because that reset is asynchronous. The bench drives operands on the falling clock edge and samples data_o on the following falling edge, after exactly one rising edge has passed. For the latency check it also samples once before that rising edge, to confirm that the previous result is still held. The bound checker compares data_o against the operands seen at the previous edge. It only does so once a full cycle has passed since reset release, so that no check looks back to operands captured while the registers were held at zero.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  typedef struct packed {
    logic right;
    logic arith;
  } shift_ctrl_t;
endpackage

// File: rtl/shifter_in_reg.sv
module shifter_in_reg
  import shifter_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shift_ctrl_t       ctrl_i,
  output logic [DATA_W-1:0] data_q_o,
  output logic [AMT_W-1:0]  amt_q_o,
  output shift_ctrl_t       ctrl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      amt_q_o  <= '0;
      ctrl_q_o <= '0;
    end else begin
      data_q_o <= data_i;
      amt_q_o  <= amt_i;
      ctrl_q_o <= ctrl_i;
    end
  end
endmodule

// File: rtl/shifter_stage.sv
module shifter_stage #(
  parameter int DATA_W = 16,
  parameter int DIST   = 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  input  logic              right_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] to_right;
  logic [DATA_W-1:0] to_left;

  assign to_right = {{DIST{fill_i}}, data_i[DATA_W-1:DIST]};
  assign to_left  = {data_i[DATA_W-1-DIST:0], {DIST{1'b0}}};

  always_comb begin
    if (!en_i)        data_o = data_i;
    else if (right_i) data_o = to_right;
    else              data_o = to_left;
  end
endmodule

// File: rtl/barrel_shift16.sv
module barrel_shift16
  import shifter_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              right_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q;
  logic [AMT_W-1:0]  amt_q;
  shift_ctrl_t       ctrl_d;
  shift_ctrl_t       ctrl_q;
  logic              fill;
  logic [DATA_W-1:0] chain [AMT_W+1];

  assign ctrl_d.right = right_i;
  assign ctrl_d.arith = signed_i;

  shifter_in_reg #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_in_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .amt_i    (amt_i),
    .ctrl_i   (ctrl_d),
    .data_q_o (data_q),
    .amt_q_o  (amt_q),
    .ctrl_q_o (ctrl_q)
  );

  // fill source is the captured MSB; arithmetic shifts keep MSB fixed across stages
  assign fill     = ctrl_q.right & ctrl_q.arith & data_q[DATA_W-1];
  assign chain[0] = data_q;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    shifter_stage #(.DATA_W(DATA_W), .DIST(1 << k)) u_stage (
      .data_i  (chain[k]),
      .en_i    (amt_q[k]),
      .right_i (ctrl_q.right),
      .fill_i  (fill),
      .data_o  (chain[k+1])
    );
  end

  assign data_o = chain[AMT_W];
endmodule

// File: rtl/barrel_shift16_chk.sv
module barrel_shift16_chk #(
  parameter int DATA_W = 16,
  parameter int AMT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [AMT_W-1:0]  amt_i,
  input logic              right_i,
  input logic              signed_i,
  input logic [DATA_W-1:0] data_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> data_o == '0); // R2

  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(amt_i) == '0 |-> data_o == $past(data_i)); // R6

  AST_LEFT_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (!$past(right_i) && $past(amt_i) != '0) |-> data_o[0] == 1'b0); // R3

  AST_LOGIC_MSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(right_i) && !$past(signed_i) && $past(amt_i) != '0) |-> data_o[DATA_W-1] == 1'b0); // R4

  AST_ARITH_MSB_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(right_i) && $past(signed_i)) |-> data_o[DATA_W-1] == $past(data_i[DATA_W-1])); // R5

  AST_ARITH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(right_i) && $past(signed_i) && $past(amt_i) == AMT_W'(DATA_W-1))
      |-> data_o == {DATA_W{$past(data_i[DATA_W-1])}}); // R7
endmodule

bind barrel_shift16 barrel_shift16_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .data_i   (data_i),
  .amt_i    (amt_i),
  .right_i  (right_i),
  .signed_i (signed_i),
  .data_o   (data_o)
);

// File: tb/sim_barrel_shift16.sv
module sim_barrel_shift16;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  // {right, signed, amt[3:0], din[15:0], expected[15:0]}
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd0,  16'hA5C3, 16'hA5C3},  // R6
    {1'b0, 1'b0, 4'd4,  16'h00FF, 16'h0FF0},  // R3
    {1'b0, 1'b1, 4'd4,  16'h8001, 16'h0010},  // R3 signed ignored
    {1'b0, 1'b1, 4'd15, 16'h0001, 16'h8000},  // R3
    {1'b1, 1'b0, 4'd4,  16'hF000, 16'h0F00},  // R4
    {1'b1, 1'b1, 4'd4,  16'hF000, 16'hFF00},  // R5
    {1'b1, 1'b1, 4'd4,  16'h7000, 16'h0700},  // R5
    {1'b1, 1'b1, 4'd15, 16'h8000, 16'hFFFF},  // R7
    {1'b1, 1'b1, 4'd15, 16'h7FFF, 16'h0000},  // R7
    {1'b1, 1'b0, 4'd15, 16'h8000, 16'h0001},  // R4
    {1'b1, 1'b1, 4'd0,  16'h8421, 16'h8421},  // R6
    {1'b1, 1'b1, 4'd1,  16'h8421, 16'hC210},  // R5
    {1'b0, 1'b0, 4'd1,  16'h8421, 16'h0842},  // R3
    {1'b1, 1'b0, 4'd8,  16'hABCD, 16'h00AB},  // R4
    {1'b1, 1'b1, 4'd8,  16'hABCD, 16'hFFAB},  // R5
    {1'b0, 1'b0, 4'd8,  16'hABCD, 16'hCD00},  // R3
    {1'b1, 1'b1, 4'd3,  16'h9000, 16'hF200},  // R5
    {1'b0, 1'b1, 4'd7,  16'h0003, 16'h0180}   // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic [3:0]  amt_i = '0;
  logic        right_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [15:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  barrel_shift16 u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .amt_i    (amt_i),
    .right_i  (right_i),
    .signed_i (signed_i),
    .data_o   (data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (data_o !== exp) begin
      n_bad++;
      $display("FAIL %s: data_o=%h expected=%h", req, data_o, exp);
    end
  endtask

  // drive at falling edge, result is due after the next rising edge
  task automatic apply(input logic r, input logic s, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    right_i = r; signed_i = s; amt_i = a; data_i = d;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] exp;
    data_i = 16'hFFFF; amt_i = 4'd3;
    repeat (3) @(negedge clk_i);
    check("R2 held in reset", 16'h0000);
    rst_ni = 1'b1;
    check("R2 after release", 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][37], VEC[i][36], VEC[i][35:32], VEC[i][31:16]);
      check($sformatf("table vec %0d", i), VEC[i][15:0]);
    end

    // R1: new operands have no effect before the rising edge
    apply(1'b0, 1'b0, 4'd0, 16'h1234);
    right_i = 1'b1; amt_i = 4'd4; data_i = 16'hFFFF;
    #1;
    check("R1 before edge", 16'h1234);
    @(negedge clk_i);
    check("R1 after edge", 16'h0FFF);

    // R8: sweep every distance in each mode
    for (int a = 0; a < 16; a++) begin
      apply(1'b0, 1'b1, 4'(a), 16'hC3A5);
      exp = 16'hC3A5 << a;
      check($sformatf("R8 left amt=%0d", a), exp);
      apply(1'b1, 1'b0, 4'(a), 16'hC3A5);
      exp = 16'hC3A5 >> a;
      check($sformatf("R8 logical right amt=%0d", a), exp);
      apply(1'b1, 1'b1, 4'(a), 16'hC3A5);
      exp = 16'($signed(16'hC3A5) >>> a);
      check($sformatf("R8 arith right amt=%0d", a), exp);
    end

    // R6 zero distance in every mode
    for (int m = 0; m < 4; m++) begin
      apply(m[1], m[0], 4'd0, 16'h9E37);
      check($sformatf("R6 mode %0d", m), 16'h9E37);
    end

    // R2: asynchronous reset mid-run
    apply(1'b0, 1'b0, 4'd0, 16'hBEEF);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R2 async clear", 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check("R2 stays zero", 16'h0000);
    apply(1'b1, 1'b1, 4'd15, 16'h8000);
    check("R7 after reset", 16'hFFFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule